// File: doc/BRIEF.md
# Card Memory Cycle Sequencer

This block runs one 16-bit memory access on a PC Card socket. A request arrives with a direction, an attribute or common space flag, an address, write data and the choice of one of two timer sets. The sequencer then drives the socket through three phases. In setup, the chip enables, attribute select, address and write data are valid before any strobe. In command, the read or write strobe is asserted. In recovery, the strobe is released while address and data are still held. When recovery ends, the block returns to idle and pulses done for one clock.

Each phase length comes from an 8-bit timing register. The top two bits select a multiplier and the low six bits give a count. There are two sets of three such registers, written through a small index-addressed write port. The card can stretch the command phase by asserting its active-low wait line. On a read, the card data is captured on the last command clock, while the read strobe is still low.

Top module: `card_mem_seq`

## Requirements
- R1: After reset and whenever idle, both chip enables are high, the read and write strobes are high, the data drive enable is low and done is low.
- R2: A timing register value v gives the length (M × v[5:0]) + 1 clocks, where M is 1, 16, 256 or 4096 for v[7:6] = 0, 1, 2 or 3. The setup phase lasts S clocks. During setup both chip enables are low, card_reg_n is the inverse of req_attr, card_addr equals the requested address, and both strobes are high.
- R3: The command phase lasts C clocks when wait is not asserted. card_oe_n is low for a read (req_write=0) and card_we_n is low for a write (req_write=1), never both.
- R4: The recovery phase lasts R clocks with both strobes high. Chip enables, address and write data stay unchanged from the accept clock until done.
- R5: Timer set 0 is written at cfg_addr 8'h3A/8'h3B/8'h3C (setup/command/recovery) and timer set 1 at 8'h3D/8'h3E/8'h3F. req_set chooses the set at accept time, and writing one set leaves the other unchanged.
- R6: After reset, both timer sets hold setup 8'h01, command 8'h06 and recovery 8'h03, giving S=2, C=7, R=4.
- R7: If card_wait_n is low from the first command clock on for H clocks, the strobe stays low for exactly 1 + H + 4 command clocks. The 4 comes from the two-flop synchronizer plus a fixed two-clock tail after release.
- R8: A synchronized wait that is active only within the first two command clocks has no effect, and the command phase keeps its programmed length C.
- R9: On a read, rd_data takes the card_d_in value present during the last clock in which card_oe_n is low.
- R10: done is high for exactly one clock, on the first idle clock after recovery. A request raised while busy is ignored.
- R11: On a write, card_d_oe is high and card_d_out equals the write data through all three phases. On a read, card_d_oe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_addr | input | 8 | Timing register index (8'h3A..8'h3F) |
| cfg_wdata | input | 8 | Timing register value: [7:6] multiplier code, [5:0] count |
| req | input | 1 | Start a cycle (taken only while idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_attr | input | 1 | 1 = attribute space (card_reg_n low) |
| req_set | input | 1 | Timer set select |
| req_addr | input | ADDR_W | Card address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse at cycle end |
| rd_data | output | DATA_W | Captured read data |
| card_ce_n | output | 2 | Chip enables, both low for a word access |
| card_reg_n | output | 1 | Attribute space select, active low |
| card_addr | output | ADDR_W | Card address bus |
| card_oe_n | output | 1 | Read strobe, active low |
| card_we_n | output | 1 | Write strobe, active low |
| card_d_out | output | DATA_W | Card data out |
| card_d_oe | output | 1 | Card data drive enable |
| card_d_in | input | DATA_W | Card data in |
| card_wait_n | input | 1 | Card wait, active low |

## Verification
The clock edge that accepts a request is followed by exactly S setup clocks, then C command clocks (or 1 + H + 4 under wait), then R recovery clocks. done appears on the next clock. The bench samples every output at the falling edge and classifies each sample by which strobes and enables are low. It counts the samples in each class and compares the counts with lengths it computes itself from the register values. Read data is presented only during the single command clock the bench expects to be the last. Wait and stray requests are driven at falling edges, so every effect lands on a known rising edge.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  localparam int PRE_W       = 2;
  localparam int CNT_FIELD_W = 6;
  localparam int TREG_W      = PRE_W + CNT_FIELD_W;
  localparam int MAX_SHIFT   = 4 * ((1 << PRE_W) - 1);
  localparam int LEN_W       = MAX_SHIFT + CNT_FIELD_W + 1;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_CMD   = 2'd2,
    PH_RECOV = 2'd3
  } phase_e;

  // length = count << (4 * code) + 1  (multiplier 1, 16, 256, 4096)
  function automatic logic [LEN_W-1:0] phase_len(input logic [TREG_W-1:0] v);
    logic [LEN_W-1:0] cnt;
    cnt = LEN_W'(v[CNT_FIELD_W-1:0]);
    return (cnt << (4 * int'(v[TREG_W-1:CNT_FIELD_W]))) + LEN_W'(1);
  endfunction

endpackage

// File: rtl/card_seq_sync.sv
module card_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/card_seq_timregs.sv
module card_seq_timregs
  import card_seq_pkg::*;
#(
  parameter int          NSETS = 2,
  parameter logic [7:0]  BASE  = 8'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [TREG_W-1:0] cfg_wdata,
  input  logic              set_sel,
  output logic [TREG_W-1:0] setup_reg,
  output logic [TREG_W-1:0] cmd_reg,
  output logic [TREG_W-1:0] recov_reg
);
  localparam int NPH = 3;

  function automatic logic [TREG_W-1:0] rst_val(input int ph);
    case (ph)
      0:       return TREG_W'(8'h01);
      1:       return TREG_W'(8'h06);
      default: return TREG_W'(8'h03);
    endcase
  endfunction

  logic [TREG_W-1:0] regs [NSETS][NPH];

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    for (genvar p = 0; p < NPH; p++) begin : g_ph
      localparam logic [7:0] IDX = BASE + 8'(s * NPH + p);
      logic [TREG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        q <= rst_val(p);
        else if (cfg_we && cfg_addr == IDX) q <= cfg_wdata;
      end
      assign regs[s][p] = q;
    end
  end

  always_comb begin
    setup_reg = regs[0][0];
    cmd_reg   = regs[0][1];
    recov_reg = regs[0][2];
    for (int s = 0; s < NSETS; s++) begin
      if (int'(set_sel) == s) begin
        setup_reg = regs[s][0];
        cmd_reg   = regs[s][1];
        recov_reg = regs[s][2];
      end
    end
  end
endmodule

// File: rtl/card_seq_core.sv
module card_seq_core
  import card_seq_pkg::*;
#(
  parameter int ADDR_W      = 26,
  parameter int DATA_W      = 16,
  parameter int WAIT_IGNORE = 2,
  parameter int WAIT_TAIL   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic              req_attr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LEN_W-1:0]  len_s,
  input  logic [LEN_W-1:0]  len_c,
  input  logic [LEN_W-1:0]  len_r,
  input  logic              wait_s,
  input  logic [DATA_W-1:0] card_d_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        card_ce_n,
  output logic              card_reg_n,
  output logic [ADDR_W-1:0] card_addr,
  output logic              card_oe_n,
  output logic              card_we_n,
  output logic [DATA_W-1:0] card_d_out,
  output logic              card_d_oe,
  output logic              accept,
  output logic              setup_end,
  output logic              cmd_end,
  output logic              recov_end,
  output logic              wait_q
);
  localparam int TAIL_W = (WAIT_TAIL < 2) ? 1 : $clog2(WAIT_TAIL + 1);

  phase_e            phase, phase_nx;
  logic [LEN_W-1:0]  elapsed, lat_s, lat_c, lat_r;
  logic [TAIL_W-1:0] tail;
  logic              lat_wr, lat_attr;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;

  assign accept    = (phase == PH_IDLE) && req;
  assign setup_end = (phase == PH_SETUP) && (elapsed >= lat_s);
  assign wait_q    = (phase == PH_CMD) && wait_s && (elapsed > LEN_W'(WAIT_IGNORE));
  assign cmd_end   = (phase == PH_CMD) && (elapsed >= lat_c) && !wait_q && (tail == '0);
  assign recov_end = (phase == PH_RECOV) && (elapsed >= lat_r);

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE:  if (accept)    phase_nx = PH_SETUP;
      PH_SETUP: if (setup_end) phase_nx = PH_CMD;
      PH_CMD:   if (cmd_end)   phase_nx = PH_RECOV;
      default:  if (recov_end) phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      elapsed   <= LEN_W'(1);
      tail      <= '0;
      done      <= 1'b0;
      rd_data   <= '0;
      lat_s     <= LEN_W'(1);
      lat_c     <= LEN_W'(1);
      lat_r     <= LEN_W'(1);
      lat_wr    <= 1'b0;
      lat_attr  <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else begin
      phase <= phase_nx;
      done  <= recov_end;
      if (phase_nx != phase)  elapsed <= LEN_W'(1);
      else if (~&elapsed)     elapsed <= elapsed + LEN_W'(1);
      if (phase != PH_CMD)    tail <= '0;
      else if (wait_q)        tail <= TAIL_W'(WAIT_TAIL);
      else if (tail != '0)    tail <= tail - TAIL_W'(1);
      if (accept) begin
        lat_s     <= len_s;
        lat_c     <= len_c;
        lat_r     <= len_r;
        lat_wr    <= req_write;
        lat_attr  <= req_attr;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
      if (cmd_end && !lat_wr) rd_data <= card_d_in;
    end
  end

  assign busy       = (phase != PH_IDLE);
  assign card_ce_n  = busy ? 2'b00 : 2'b11;
  assign card_reg_n = busy ? ~lat_attr : 1'b1;
  assign card_addr  = lat_addr;
  assign card_oe_n  = !((phase == PH_CMD) && !lat_wr);
  assign card_we_n  = !((phase == PH_CMD) && lat_wr);
  assign card_d_out = lat_wdata;
  assign card_d_oe  = busy && lat_wr;
endmodule

// File: rtl/card_mem_seq.sv
module card_mem_seq
  import card_seq_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              req,
  input  logic              req_write,
  input  logic              req_attr,
  input  logic              req_set,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        card_ce_n,
  output logic              card_reg_n,
  output logic [ADDR_W-1:0] card_addr,
  output logic              card_oe_n,
  output logic              card_we_n,
  output logic [DATA_W-1:0] card_d_out,
  output logic              card_d_oe,
  input  logic [DATA_W-1:0] card_d_in,
  input  logic              card_wait_n
);
  logic [TREG_W-1:0] setup_reg, cmd_reg, recov_reg;
  logic [LEN_W-1:0]  len_s, len_c, len_r;
  logic              wait_s;
  logic              accept, setup_end, cmd_end, recov_end, wait_q;

  card_seq_timregs #(.NSETS(2), .BASE(8'h3A)) timregs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .set_sel(req_set),
    .setup_reg(setup_reg), .cmd_reg(cmd_reg), .recov_reg(recov_reg)
  );

  assign len_s = phase_len(setup_reg);
  assign len_c = phase_len(cmd_reg);
  assign len_r = phase_len(recov_reg);

  card_seq_sync #(.STAGES(2)) wait_sync_i (
    .clk(clk), .rst_n(rst_n), .d(~card_wait_n), .q(wait_s)
  );

  card_seq_core #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_IGNORE(2), .WAIT_TAIL(2)
  ) core_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_attr(req_attr), .req_addr(req_addr), .req_wdata(req_wdata),
    .len_s(len_s), .len_c(len_c), .len_r(len_r), .wait_s(wait_s),
    .card_d_in(card_d_in), .busy(busy), .done(done), .rd_data(rd_data),
    .card_ce_n(card_ce_n), .card_reg_n(card_reg_n), .card_addr(card_addr),
    .card_oe_n(card_oe_n), .card_we_n(card_we_n), .card_d_out(card_d_out),
    .card_d_oe(card_d_oe), .accept(accept), .setup_end(setup_end),
    .cmd_end(cmd_end), .recov_end(recov_end), .wait_q(wait_q)
  );
endmodule

// File: rtl/card_mem_seq_chk.sv
module card_mem_seq_chk #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              accept,
  input logic              cmd_end,
  input logic              recov_end,
  input logic              wait_q,
  input logic [1:0]        card_ce_n,
  input logic              card_oe_n,
  input logic              card_we_n,
  input logic              card_d_oe,
  input logic [ADDR_W-1:0] card_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] card_d_in
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (card_ce_n == 2'b11) && card_oe_n && card_we_n && !card_d_oe);

  p_setup_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (card_ce_n == 2'b00) && card_oe_n && card_we_n);

  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!card_oe_n && !card_we_n));

  p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !recov_end) |=> $stable(card_addr) && (card_ce_n == 2'b00));

  p_wait_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |=> !(card_oe_n && card_we_n));

  p_read_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_end && card_we_n) |=> rd_data == $past(card_d_in));

  p_done_after_recov_r10: assert property (@(posedge clk) disable iff (!rst_n)
    recov_end |=> done && !busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind card_mem_seq card_mem_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/card_mem_seq_tb_top.sv
module card_mem_seq_tb_top;
  localparam int AW = 26;
  localparam int DW = 16;

  typedef struct packed {
    logic          set;
    logic          wr;
    logic          attr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic [7:0]    s;
    logic [7:0]    c;
    logic [7:0]    r;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 26'h0001234, 16'hA5A5, 16'h0000, 8'h00, 8'h00, 8'h00},
    '{1'b0, 1'b0, 1'b1, 26'h3FFFFFF, 16'h0000, 16'h5AC3, 8'h01, 8'h06, 8'h03},
    '{1'b1, 1'b1, 1'b1, 26'h00ABCDE, 16'h1357, 16'h0000, 8'h42, 8'h05, 8'h81},
    '{1'b1, 1'b0, 1'b0, 26'h2000001, 16'h0000, 16'h1234, 8'h3F, 8'h43, 8'h00},
    '{1'b0, 1'b0, 1'b0, 26'h1555555, 16'h0000, 16'hFEDC, 8'hC1, 8'h01, 8'h02},
    '{1'b1, 1'b1, 1'b0, 26'h0FEDCBA, 16'h8001, 16'h0000, 8'h02, 8'h7F, 8'h01}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_addr = 8'h00;
  logic [7:0]    cfg_wdata = 8'h00;
  logic          req = 1'b0;
  logic          req_write = 1'b0;
  logic          req_attr = 1'b0;
  logic          req_set = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          busy, done;
  logic [DW-1:0] rd_data;
  logic [1:0]    card_ce_n;
  logic          card_reg_n;
  logic [AW-1:0] card_addr;
  logic          card_oe_n, card_we_n;
  logic [DW-1:0] card_d_out;
  logic          card_d_oe;
  logic [DW-1:0] card_d_in = '0;
  logic          card_wait_n = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  card_mem_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req(req), .req_write(req_write),
    .req_attr(req_attr), .req_set(req_set), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .card_ce_n(card_ce_n), .card_reg_n(card_reg_n), .card_addr(card_addr),
    .card_oe_n(card_oe_n), .card_we_n(card_we_n), .card_d_out(card_d_out),
    .card_d_oe(card_d_oe), .card_d_in(card_d_in), .card_wait_n(card_wait_n)
  );

  function automatic int exp_len(input logic [7:0] v);
    int m;
    case (v[7:6])
      2'd0:    m = 1;
      2'd1:    m = 16;
      2'd2:    m = 256;
      default: m = 4096;
    endcase
    return m * int'(v[5:0]) + 1;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic program_set(input logic set, input logic [7:0] s,
                             input logic [7:0] c, input logic [7:0] r);
    logic [7:0] base;
    base = set ? 8'h3D : 8'h3A;
    cfg_write(base, s);
    cfg_write(base + 8'h01, c);
    cfg_write(base + 8'h02, r);
  endtask

  // wmode 0: no wait; 1: wait pin low only in last setup clock;
  // 2: wait pin low from first command clock for wlen clocks
  task automatic run_vec(input vec_t v, input int wmode, input int wlen, input bit poke);
    int es, ec, er, ns, nc, nr;
    bit addr_bad, dout_bad, strobe_bad;
    es = exp_len(v.s);
    er = exp_len(v.r);
    ec = (wmode == 2) ? (1 + wlen + 4) : exp_len(v.c);
    ns = 0; nc = 0; nr = 0;
    addr_bad = 0; dout_bad = 0; strobe_bad = 0;
    @(negedge clk);
    req = 1'b1; req_write = v.wr; req_attr = v.attr; req_set = v.set;
    req_addr = v.addr; req_wdata = v.wdata; card_d_in = ~v.rdata;
    @(negedge clk);
    while (card_ce_n == 2'b00 && card_oe_n && card_we_n) begin
      ns++;
      if (card_addr != v.addr || card_reg_n != ~v.attr) addr_bad = 1;
      if (card_d_oe != v.wr || (v.wr && card_d_out != v.wdata)) dout_bad = 1;
      req = poke && (ns == 1);
      req_addr = ~v.addr;
      card_wait_n = !((wmode == 1) && (ns == es));
      @(negedge clk);
    end
    req = 1'b0;
    chk(ns == es, "R2", "setup clocks", ns, es);
    while (card_ce_n == 2'b00 && !(card_oe_n && card_we_n)) begin
      nc++;
      if (card_oe_n == v.wr ? 1'b0 : 1'b1) strobe_bad = 1;
      if (card_we_n == v.wr) strobe_bad = 1;
      if (card_addr != v.addr) addr_bad = 1;
      if (card_d_oe != v.wr || (v.wr && card_d_out != v.wdata)) dout_bad = 1;
      card_d_in = (nc == ec) ? v.rdata : ~v.rdata;
      if (wmode == 2) begin
        if (nc == 1) card_wait_n = 1'b0;
        if (nc == 1 + wlen) card_wait_n = 1'b1;
      end else begin
        card_wait_n = 1'b1;
      end
      @(negedge clk);
    end
    card_wait_n = 1'b1;
    if (wmode == 2)      chk(nc == ec, "R7", "stretched command clocks", nc, ec);
    else if (wmode == 1) chk(nc == ec, "R8", "command clocks with early wait", nc, ec);
    else                 chk(nc == ec, "R3", "command clocks", nc, ec);
    chk(!strobe_bad, "R3", "strobe matches direction", strobe_bad, 0);
    while (card_ce_n == 2'b00 && card_oe_n && card_we_n) begin
      nr++;
      if (card_addr != v.addr) addr_bad = 1;
      if (card_d_oe != v.wr || (v.wr && card_d_out != v.wdata)) dout_bad = 1;
      @(negedge clk);
    end
    chk(nr == er, "R4", "recovery clocks", nr, er);
    chk(!addr_bad, "R4", "address/attr held", addr_bad, 0);
    chk(!dout_bad, "R11", "write data drive", dout_bad, 0);
    chk(done == 1'b1 && card_ce_n == 2'b11, "R10", "done on first idle clock",
        {done, card_ce_n}, 3'b111);
    if (!v.wr) chk(rd_data == v.rdata, "R9", "read data", rd_data, v.rdata);
    @(negedge clk);
    chk(done == 1'b0 && card_ce_n == 2'b11 && !busy, "R10", "done one clock, no stray accept",
        {done, busy, card_ce_n}, 4'b0011);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(card_ce_n == 2'b11 && card_oe_n && card_we_n && !card_d_oe && !done && !busy,
        "R1", "outputs in reset", {card_ce_n, card_oe_n, card_we_n, card_d_oe, done},
        6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(card_ce_n == 2'b11 && card_oe_n && card_we_n && !card_d_oe && !done,
        "R1", "idle after reset", {card_ce_n, card_oe_n, card_we_n, card_d_oe, done},
        6'b111100);

    // R6: reset timer values in both sets (S=2, C=7, R=4)
    run_vec('{1'b0, 1'b1, 1'b0, 26'h0000AAA, 16'h00FF, 16'h0000, 8'h01, 8'h06, 8'h03}, 0, 0, 0);
    run_vec('{1'b1, 1'b0, 1'b1, 26'h0000555, 16'h0000, 16'hBEEF, 8'h01, 8'h06, 8'h03}, 0, 0, 0);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      program_set(VECS[i].set, VECS[i].s, VECS[i].c, VECS[i].r);
      run_vec(VECS[i], 0, 0, (i == 1));
    end

    // R5: set 1 writes leave set 0 intact
    program_set(1'b0, 8'h02, 8'h06, 8'h01);
    program_set(1'b1, 8'h00, 8'h00, 8'h00);
    run_vec('{1'b0, 1'b0, 1'b0, 26'h0123456, 16'h0000, 16'h4321, 8'h02, 8'h06, 8'h01}, 0, 0, 0);
    run_vec('{1'b1, 1'b1, 1'b0, 26'h0123457, 16'h7777, 16'h0000, 8'h00, 8'h00, 8'h00}, 0, 0, 1);

    // R8: wait only within the first two command clocks is ignored
    run_vec('{1'b0, 1'b0, 1'b1, 26'h0002222, 16'h0000, 16'h0F0F, 8'h02, 8'h06, 8'h01}, 1, 0, 0);

    // R7: wait stretches the command strobe
    program_set(1'b1, 8'h01, 8'h02, 8'h01);
    run_vec('{1'b1, 1'b0, 1'b0, 26'h0003333, 16'h0000, 16'hC0DE, 8'h01, 8'h02, 8'h01}, 2, 20, 0);
    run_vec('{1'b1, 1'b1, 1'b1, 26'h0004444, 16'h2468, 16'h0000, 8'h01, 8'h02, 8'h01}, 2, 7, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule